// File: doc/BRIEF.md
# Mantissa-Exponent Sample to Linear PCM Converter

This block turns one audio sample in compressed form into a 16-bit linear word. The sample has a 10-bit two's-complement mantissa and a 3-bit exponent code. The exponent sets where the mantissa sits inside the 16-bit result. The output therefore always carries 10 significant bits, whether the signal is quiet or loud. A quiet sample keeps its full 10-bit precision in the low bits. A loud sample is moved up to the top of the word.

The converter sits after a serial capture stage and before any linear audio processing. Each input word is qualified by a valid strobe. One clock later the converter presents a registered result with its own valid strobe. An error flag marks a sample that carried the one exponent code with no legal meaning.

Top module: `fp_sample_to_linear`

## Requirements
- R1: While reset is held and after it is released with no input, `out_valid`, `out_err` and `out_data` are all zero.
- R2: `out_valid` is high exactly one clock after a cycle with `in_valid` high, and low one clock after a cycle with `in_valid` low.
- R3: Exponent code 0 is illegal. An accepted sample with code 0 gives `out_err` = 1 and `out_data` = 0 in the same cycle as its `out_valid`.
- R4: Exponent codes 1 to 7 are legal. Their results have `out_err` = 0, and `out_err` is never high without `out_valid`.
- R5: A legal code k places the mantissa shifted left by k-1 bit positions. All output bits below the mantissa are zero.
- R6: Code 1 puts the mantissa in output bits 0 to 9, with bits 10 to 15 filled with copies of the mantissa sign bit (bit 9).
- R7: Code 7 puts the mantissa in output bits 6 to 15, and output bits 0 to 5 are zero.
- R8: The mantissa is signed. A negative mantissa (bit 9 set) produces a result equal to its value times 2^(k-1), taken modulo 2^16, so the upper bits are ones.
- R9: In a cycle where `out_valid` is low, `out_data` keeps the last value it was given.
- R10: Samples presented on consecutive cycles produce results on consecutive cycles, in the same order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample strobe |
| in_mant | input | 10 | Two's-complement mantissa |
| in_exp | input | 3 | Exponent code (0 illegal, 1..7 = shift 0..6) |
| out_valid | output | 1 | Result strobe, one cycle after input |
| out_data | output | 16 | Linear two's-complement result |
| out_err | output | 1 | High with out_valid when the exponent code was illegal |

## Verification
Every result, the error flag included, is due exactly one clock after its input is accepted. The driver records the cycle on which it presents each sample together with the expected word. The monitor samples at the falling edge. On every result it checks that the stamped cycle plus one equals the current cycle, and a result with nothing queued counts as a timing error. Idle cycles in between are used to check that the data is held.

// File: rtl/fp_sample_to_linear_pkg.sv
package fp_sample_to_linear_pkg;
  localparam int DEF_MANT_W   = 10;
  localparam int DEF_EXP_W    = 3;
  localparam int DEF_OUT_W    = 16;
  localparam int ILLEGAL_CODE = 0;
endpackage

// File: rtl/exp_level_decode.sv
module exp_level_decode #(
  parameter int EXP_W     = 3,
  parameter int MAX_SHIFT = 6,
  localparam int SHIFT_W  = (MAX_SHIFT < 1) ? 1 : $clog2(MAX_SHIFT + 1)
) (
  input  logic [EXP_W-1:0]   code,
  output logic               legal,
  output logic [SHIFT_W-1:0] shift
);
  import fp_sample_to_linear_pkg::*;

  function automatic logic code_ok(input logic [EXP_W-1:0] c);
    int v;
    v = int'(c);
    return (v != ILLEGAL_CODE) && ((v - 1) <= MAX_SHIFT);
  endfunction

  function automatic logic [SHIFT_W-1:0] code_shift(input logic [EXP_W-1:0] c);
    int v;
    v = int'(c);
    if (v == ILLEGAL_CODE || (v - 1) > MAX_SHIFT) return '0;
    return SHIFT_W'(v - 1);
  endfunction

  always_comb begin
    legal = code_ok(code);
    shift = code_shift(code);
  end
endmodule

// File: rtl/mant_window.sv
module mant_window #(
  parameter int MANT_W    = 10,
  parameter int OUT_W     = 16,
  parameter int MAX_SHIFT = 6,
  localparam int SHIFT_W  = (MAX_SHIFT < 1) ? 1 : $clog2(MAX_SHIFT + 1),
  localparam int EXT_W    = OUT_W - MANT_W
) (
  input  logic [MANT_W-1:0]  mant,
  input  logic [SHIFT_W-1:0] shift,
  output logic [OUT_W-1:0]   placed
);
  logic [OUT_W-1:0] ext;
  logic [OUT_W-1:0] cand [MAX_SHIFT+1];

  assign ext = {{EXT_W{mant[MANT_W-1]}}, mant};

  for (genvar s = 0; s <= MAX_SHIFT; s++) begin : g_lvl
    assign cand[s] = ext << s;
  end

  always_comb begin
    placed = '0;
    for (int i = 0; i <= MAX_SHIFT; i++) begin
      if (int'(shift) == i) placed = cand[i];
    end
  end
endmodule

// File: rtl/sample_out_reg.sv
module sample_out_reg #(
  parameter int OUT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             legal,
  input  logic [OUT_W-1:0] word,
  output logic             q_valid,
  output logic             q_err,
  output logic [OUT_W-1:0] q_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_err   <= 1'b0;
      q_data  <= '0;
    end else begin
      q_valid <= take;
      q_err   <= take && !legal;
      if (take) q_data <= legal ? word : '0;
    end
  end
endmodule

// File: rtl/fp_sample_to_linear.sv
module fp_sample_to_linear
  import fp_sample_to_linear_pkg::*;
#(
  parameter int MANT_W = DEF_MANT_W,
  parameter int EXP_W  = DEF_EXP_W,
  parameter int OUT_W  = DEF_OUT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [MANT_W-1:0] in_mant,
  input  logic [EXP_W-1:0]  in_exp,
  output logic              out_valid,
  output logic [OUT_W-1:0]  out_data,
  output logic              out_err
);
  localparam int MAX_SHIFT = OUT_W - MANT_W;
  localparam int SHIFT_W   = (MAX_SHIFT < 1) ? 1 : $clog2(MAX_SHIFT + 1);

  logic               code_legal;
  logic [SHIFT_W-1:0] shift_amt;
  logic [OUT_W-1:0]   placed_word;

  exp_level_decode #(.EXP_W(EXP_W), .MAX_SHIFT(MAX_SHIFT)) u_dec (
    .code (in_exp),
    .legal(code_legal),
    .shift(shift_amt)
  );

  mant_window #(.MANT_W(MANT_W), .OUT_W(OUT_W), .MAX_SHIFT(MAX_SHIFT)) u_win (
    .mant  (in_mant),
    .shift (shift_amt),
    .placed(placed_word)
  );

  sample_out_reg #(.OUT_W(OUT_W)) u_reg (
    .clk    (clk),
    .rst_n  (rst_n),
    .take   (in_valid),
    .legal  (code_legal),
    .word   (placed_word),
    .q_valid(out_valid),
    .q_err  (out_err),
    .q_data (out_data)
  );
endmodule

// File: rtl/fp_sample_to_linear_chk.sv
module fp_sample_to_linear_chk #(
  parameter int MANT_W = 10,
  parameter int EXP_W  = 3,
  parameter int OUT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [MANT_W-1:0] in_mant,
  input logic [EXP_W-1:0]  in_exp,
  input logic              out_valid,
  input logic [OUT_W-1:0]  out_data,
  input logic              out_err
);
  localparam int MAX_SHIFT = OUT_W - MANT_W;
  localparam int EXT_W     = OUT_W - MANT_W;

  // R2
  valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R2
  idle_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R3
  bad_code_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_exp == '0) |=> (out_err && out_data == '0));
  // R4
  err_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_err |-> out_valid);
  // R4
  good_code_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_exp != '0) |=> !out_err);
  // R6
  low_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_exp == EXP_W'(1)) |=>
      (out_data[MANT_W-1:0] == $past(in_mant) &&
       out_data[OUT_W-1:MANT_W] == {EXT_W{$past(in_mant[MANT_W-1])}}));
  // R7
  high_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_exp == EXP_W'(MAX_SHIFT + 1)) |=>
      (out_data[MAX_SHIFT-1:0] == '0 &&
       out_data[OUT_W-1:MAX_SHIFT] == $past(in_mant)));
  // R9
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_data));
endmodule

bind fp_sample_to_linear fp_sample_to_linear_chk #(
  .MANT_W(MANT_W), .EXP_W(EXP_W), .OUT_W(OUT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mant(in_mant),
  .in_exp(in_exp), .out_valid(out_valid), .out_data(out_data), .out_err(out_err)
);

// File: tb/test_fp_sample_to_linear.sv
module test_fp_sample_to_linear;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [9:0]  in_mant = '0;
  logic [2:0]  in_exp = '0;
  logic        out_valid;
  logic [15:0] out_data;
  logic        out_err;

  typedef struct {
    logic [15:0] data;
    logic        err;
    int          cyc;
    logic [9:0]  mant;
    logic [2:0]  code;
  } exp_item_t;

  exp_item_t sb[$];
  int   cyc = 0;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done = 0;
  bit   mon_on = 0;
  logic [15:0] last_data = '0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  fp_sample_to_linear i_fp_sample_to_linear (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mant(in_mant),
    .in_exp(in_exp), .out_valid(out_valid), .out_data(out_data), .out_err(out_err)
  );

  function automatic logic [15:0] model(input logic [9:0] m, input logic [2:0] e);
    int v;
    if (e == 3'd0) return 16'h0000;
    v = int'($signed(m)) * (1 << (int'(e) - 1));
    return v[15:0];
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, expv, cyc);
    end
  endtask

  task automatic send(input logic [9:0] m, input logic [2:0] e);
    exp_item_t it;
    @(negedge clk);
    in_valid = 1'b1; in_mant = m; in_exp = e;
    it.data = model(m, e); it.err = (e == 3'd0); it.cyc = cyc; it.mant = m; it.code = e;
    sb.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // monitor: compares every result against the queued expectation
  always @(negedge clk) begin
    if (mon_on) begin
      if (out_valid) begin
        if (sb.size() == 0) begin
          check(0, "R2 unexpected result", 1, 0);
        end else begin
          exp_item_t it;
          it = sb.pop_front();
          // R2 / R10: one cycle after issue, in order
          check(cyc == it.cyc + 1, "R2 latency", cyc, it.cyc + 1);
          // R3 / R4: error flag
          check(out_err == it.err, it.err ? "R3 err flag" : "R4 err flag", out_err, it.err);
          // R5 / R6 / R7 / R8 / R3: data
          if (it.code == 3'd0)
            check(out_data == it.data, "R3 zero data", out_data, it.data);
          else if (it.code == 3'd1)
            check(out_data == it.data, "R6 low window", out_data, it.data);
          else if (it.code == 3'd7)
            check(out_data == it.data, "R7 high window", out_data, it.data);
          else if (it.mant[9])
            check(out_data == it.data, "R8 negative", out_data, it.data);
          else
            check(out_data == it.data, "R5 placement", out_data, it.data);
          last_data = out_data;
        end
      end else begin
        check(out_err == 1'b0, "R4 err without valid", out_err, 0);
        check(out_data == last_data, "R9 hold", out_data, last_data);
      end
    end
  end

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired, actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    logic [15:0] lfsr;
    lfsr = 16'hACE1;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(out_valid == 1'b0, "R1 valid", out_valid, 0);
    check(out_err == 1'b0, "R1 err", out_err, 0);
    check(out_data == 16'h0, "R1 data", out_data, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0 && out_data == 16'h0, "R1 after release", out_data, 0);
    mon_on = 1;
    // every code with edge mantissas, spaced by idle cycles (R9)
    for (int e = 0; e < 8; e++) begin
      send(10'h3FF, 3'(e)); idle(1);
      send(10'h200, 3'(e)); idle(1);
      send(10'h1FF, 3'(e)); idle(2);
      send(10'h001, 3'(e));
      send(10'h155, 3'(e)); idle(1);
    end
    // R10: back-to-back burst across codes
    for (int k = 0; k < 16; k++) send(10'(k * 67 + 5), 3'(k % 8));
    idle(2);
    // pseudo-random stream with random gaps
    for (int k = 0; k < 300; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      send(lfsr[9:0], lfsr[12:10]);
      if (lfsr[15]) idle(int'(lfsr[14:13]));
    end
    idle(3);
    check(sb.size() == 0, "R2 all results delivered", sb.size(), 0);
    done = 1;
    finish_run();
  end
endmodule